// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit processor core. It is purely combinational. Each evaluation takes two byte operands, a 4-bit operation code and the current 8-bit status byte. It returns a byte result, a write-enable that tells the register file whether to store that result, and the next value of the status byte. Only the flags that an operation defines are rewritten. Every other status bit passes through from the status input unchanged.

Subtraction reuses the adder. The second operand is inverted and the carry-in sense is flipped. The carry and half-carry outputs are then inverted, so that they report a borrow. The with-carry subtract forms keep the zero flag sticky, so a chain of byte-wide subtractions or compares reports zero only if every byte was zero. Two dedicated operations set or clear one status bit chosen by the low three bits of operand B. These are the only operations that can change the two top status bits.

Top module: `alu8_core`

## Requirements
- R1: The status byte layout is C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4, H bit 5, T bit 6, I bit 7. The operation codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 CPC, 6 DEC, 7 AND, 8 OR, 9 XOR, 10 LSL, 11 ROL, 12 FSET, 13 FCLR, with 14 and 15 reserved. `wr_en` is 1 for codes 0-3 and 6-11 and 0 for all others.
- R2: ADD yields A+B and ADC yields A+B+C. For both, C is the carry out of bit 7, H is the carry out of bit 3, V is set when the carry into bit 7 differs from the carry out of bit 7, N is result bit 7, Z is set on a zero result, and S = N xor V.
- R3: SUB yields A-B. C is set on a borrow out of bit 7, and H is set on a borrow out of bit 3. V is set on signed overflow. N, Z and S follow the rules of R2.
- R4: SBC and CPC compute A-B-C. Z is set only if the result is zero and Z was set on entry. The other flags follow the rules of R3.
- R5: CMP computes the same flags as SUB, and CPC computes the same flags as SBC. Neither writes a result (`wr_en` = 0).
- R6: DEC yields A-1. V is set only when A was 0x80. N, Z and S are updated, and C and H keep their input values.
- R7: AND, OR and XOR clear V, set N from result bit 7, set Z on a zero result, set S = N, and keep C and H.
- R8: LSL yields A shifted left with 0 in bit 0. ROL puts the old C into bit 0. For both, C is the old bit 7, H is the old bit 3, V is the old bit 7 xor the old bit 6, and N, Z and S = N xor V are updated.
- R9: FSET sets, and FCLR clears, the status bit indexed by B[2:0]. All other status bits are unchanged. No other operation changes T or I.
- R10: Reserved codes leave the status byte unchanged and do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Operand A (destination value) |
| b_i | input | 8 | Operand B, or the bit index for FSET/FCLR |
| flags_i | input | 8 | Current status byte |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 8 | Next status byte |

## Verification
Every output is due in the same cycle in which the inputs are applied. No register lies on any path. The bench therefore changes the inputs on the falling clock edge and compares all three outputs 1 ns later, well before the next rising edge. The expected values come from a model in the bench that works in signed and unsigned integers and tests borrow and overflow by range. That model is compared against directed corner cases (0x80 and 0x7F boundaries, sticky-zero chains, nibble borrows) and a long stream of random operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W  = 8;
    localparam int HALF_W  = DATA_W / 2;
    localparam int IDX_W   = $clog2(DATA_W);

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_T = 6;
    localparam int FLAG_I = 7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_CPC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_LSL  = 4'd10,
        OP_ROL  = 4'd11,
        OP_FSET = 4'd12,
        OP_FCLR = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              c_half;
        logic              c_into_top;
        logic              c_out;
    } add_res_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] flags;
        logic              wr;
    } unit_out_t;

    function automatic add_res_t add_core(input logic [DATA_W-1:0] a,
                                          input logic [DATA_W-1:0] b,
                                          input logic              cin);
        add_res_t         r;
        logic [HALF_W:0]  lo;
        logic [DATA_W-1:0] low7;
        logic [DATA_W:0]  full;
        lo   = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        low7 = {1'b0, a[DATA_W-2:0]} + {1'b0, b[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, cin};
        full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        r.sum        = full[DATA_W-1:0];
        r.c_half     = lo[HALF_W];
        r.c_into_top = low7[DATA_W-1];
        r.c_out      = full[DATA_W];
        return r;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] fin,
    output unit_out_t         out
);
    logic              is_sub, with_c, is_dec;
    logic [DATA_W-1:0] b_eff;
    logic              cin;
    add_res_t          r;
    logic [DATA_W-1:0] dec_res;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_CPC);
        with_c = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
        is_dec = (op == OP_DEC);
        b_eff  = is_sub ? ~b : b;
        if (with_c)
            cin = is_sub ? ~fin[FLAG_C] : fin[FLAG_C];
        else
            cin = is_sub;
    end

    assign r       = add_core(a, b_eff, cin);
    assign dec_res = a - {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        out.flags = fin;
        if (is_dec) begin
            out.res            = dec_res;
            out.flags[FLAG_V]  = (a == {1'b1, {(DATA_W-1){1'b0}}});
            out.flags[FLAG_N]  = dec_res[DATA_W-1];
            out.flags[FLAG_Z]  = ~|dec_res;
        end else begin
            out.res            = r.sum;
            out.flags[FLAG_C]  = r.c_out ^ is_sub;
            out.flags[FLAG_H]  = r.c_half ^ is_sub;
            out.flags[FLAG_V]  = r.c_into_top ^ r.c_out;
            out.flags[FLAG_N]  = r.sum[DATA_W-1];
            out.flags[FLAG_Z]  = (~|r.sum) & ((is_sub && with_c) ? fin[FLAG_Z] : 1'b1);
        end
        out.flags[FLAG_S] = out.flags[FLAG_N] ^ out.flags[FLAG_V];
        out.wr = (op != OP_CMP) && (op != OP_CPC);
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] fin,
    output unit_out_t         out
);
    logic is_shift;

    always_comb begin
        is_shift  = (op == OP_LSL) || (op == OP_ROL);
        out.flags = fin;
        unique case (op)
            OP_AND:  out.res = a & b;
            OP_OR:   out.res = a | b;
            OP_XOR:  out.res = a ^ b;
            OP_ROL:  out.res = {a[DATA_W-2:0], fin[FLAG_C]};
            default: out.res = {a[DATA_W-2:0], 1'b0};
        endcase
        if (is_shift) begin
            out.flags[FLAG_C] = a[DATA_W-1];
            out.flags[FLAG_H] = a[HALF_W-1];
            out.flags[FLAG_V] = a[DATA_W-1] ^ a[DATA_W-2];
        end else begin
            out.flags[FLAG_V] = 1'b0;
        end
        out.flags[FLAG_N] = out.res[DATA_W-1];
        out.flags[FLAG_Z] = ~|out.res;
        out.flags[FLAG_S] = out.flags[FLAG_N] ^ out.flags[FLAG_V];
        out.wr = 1'b1;
    end
endmodule

// File: rtl/alu8_flagop.sv
module alu8_flagop
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] fin,
    output unit_out_t         out
);
    logic [DATA_W-1:0] sel;

    assign sel = {{(DATA_W-1){1'b0}}, 1'b1} << idx;

    always_comb begin
        out.res = '0;
        out.wr  = 1'b0;
        case (op)
            OP_FSET: out.flags = fin | sel;
            OP_FCLR: out.flags = fin & ~sel;
            default: out.flags = fin;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] flags_o
);
    alu_op_e   op;
    unit_out_t u_ar, u_bw, u_fo, sel;
    logic      cls_arith, cls_bit;

    assign op = alu_op_e'(op_i);

    alu8_arith   u_arith   (.op(op), .a(a_i), .b(b_i), .fin(flags_i), .out(u_ar));
    alu8_bitwise u_bitwise (.op(op), .a(a_i), .b(b_i), .fin(flags_i), .out(u_bw));
    alu8_flagop  u_flagop  (.op(op), .idx(b_i[IDX_W-1:0]), .fin(flags_i), .out(u_fo));

    always_comb begin
        cls_arith = (op_i <= 4'(OP_DEC));
        cls_bit   = (op_i >= 4'(OP_AND)) && (op_i <= 4'(OP_ROL));
        if (cls_arith)    sel = u_ar;
        else if (cls_bit) sel = u_bw;
        else              sel = u_fo;
    end

    assign result_o = sel.res;
    assign wr_en_o  = sel.wr;
    assign flags_o  = sel.flags;

    always_comb begin
        if (op != OP_FSET && op != OP_FCLR)
            assert_ti_hold_R9: assert (flags_o[FLAG_T] == flags_i[FLAG_T] && flags_o[FLAG_I] == flags_i[FLAG_I])
                else $error("T/I changed by op %0d", op_i);
        if (op == OP_CMP || op == OP_CPC)
            assert_cmp_nowrite_R5: assert (!wr_en_o) else $error("compare wrote a result");
        if (op == OP_SBC || op == OP_CPC)
            assert_sticky_zero_R4: assert (flags_i[FLAG_Z] || !flags_o[FLAG_Z]) else $error("sticky Z violated");
        if (op == OP_DEC)
            assert_dec_keep_ch_R6: assert (flags_o[FLAG_C] == flags_i[FLAG_C] && flags_o[FLAG_H] == flags_i[FLAG_H])
                else $error("DEC touched C/H");
        if (op == OP_AND || op == OP_OR || op == OP_XOR)
            assert_logic_flags_R7: assert (!flags_o[FLAG_V] && flags_o[FLAG_C] == flags_i[FLAG_C] && flags_o[FLAG_H] == flags_i[FLAG_H])
                else $error("logic op flag rule violated");
        if (op == OP_ADD || op == OP_ADC)
            assert_sign_rule_R2: assert (flags_o[FLAG_S] == (flags_o[FLAG_N] ^ flags_o[FLAG_V]))
                else $error("S != N^V");
        if (op == OP_RSV0 || op == OP_RSV1)
            assert_reserved_idle_R10: assert (!wr_en_o && flags_o == flags_i) else $error("reserved op acted");
    end
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op;
    logic [7:0] a, b, fl;
    logic [7:0] res;
    logic       wr;
    logic [7:0] flo;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (.op_i(op), .a_i(a), .b_i(b), .flags_i(fl),
                           .result_o(res), .wr_en_o(wr), .flags_o(flo));

    function automatic string req_of(input int o);
        case (o)
            0, 1:          return "R2";
            2:             return "R3";
            3, 5:          return "R4";
            4:             return "R5";
            6:             return "R6";
            7, 8, 9:       return "R7";
            10, 11:        return "R8";
            12, 13:        return "R9";
            default:       return "R10";
        endcase
    endfunction

    // behavioural model: integers and range tests
    task automatic model(input int o, input int ia, input int ib, input int f,
                         output int er, output int ew, output int ef);
        int c, z, k, d, h, sa, sb, s, n, v;
        c = f & 1;
        z = (f >> 1) & 1;
        ef = f;
        er = 0;
        ew = ((o <= 3) || (o >= 6 && o <= 11)) ? 1 : 0;
        sa = (ia > 127) ? ia - 256 : ia;
        sb = (ib > 127) ? ib - 256 : ib;
        if (o <= 1) begin
            k = (o == 1) ? c : 0;
            d = ia + ib + k;
            er = d % 256;
            h = ((ia % 16) + (ib % 16) + k) > 15;
            s = sa + sb + k;
            v = (s > 127 || s < -128);
            n = er >= 128;
            ef = (f & 'hC0) | (h << 5) | ((n ^ v) << 4) | (v << 3) | (n << 2) | ((er == 0) << 1) | (d > 255);
        end else if (o <= 5) begin
            k = (o == 3 || o == 5) ? c : 0;
            d = ia - ib - k;
            er = (d + 256) % 256;
            h = ((ia % 16) - (ib % 16) - k) < 0;
            s = sa - sb - k;
            v = (s > 127 || s < -128);
            n = er >= 128;
            z = (o == 3 || o == 5) ? ((er == 0) && z) : (er == 0);
            ef = (f & 'hC0) | (h << 5) | ((n ^ v) << 4) | (v << 3) | (n << 2) | (z << 1) | (d < 0);
        end else if (o == 6) begin
            er = (ia + 255) % 256;
            v = (ia == 128);
            n = er >= 128;
            ef = (f & 'hE1) | ((n ^ v) << 4) | (v << 3) | (n << 2) | ((er == 0) << 1);
        end else if (o <= 9) begin
            er = (o == 7) ? (ia & ib) : (o == 8) ? (ia | ib) : (ia ^ ib);
            n = er >= 128;
            ef = (f & 'hE1) | (n << 4) | (n << 2) | ((er == 0) << 1);
        end else if (o <= 11) begin
            er = ((ia * 2) % 256) + ((o == 11) ? c : 0);
            v = ((ia >> 7) & 1) ^ ((ia >> 6) & 1);
            n = er >= 128;
            ef = (f & 'hC0) | (((ia >> 3) & 1) << 5) | ((n ^ v) << 4) | (v << 3) | (n << 2)
                 | ((er == 0) << 1) | ((ia >> 7) & 1);
        end else if (o == 12) begin
            ef = f | (1 << (ib % 8));
        end else if (o == 13) begin
            ef = f & ~(1 << (ib % 8)) & 'hFF;
        end
    endtask

    task automatic apply(input int o, input int ia, input int ib, input int f);
        int er, ew, ef;
        @(negedge clk);
        op = 4'(o); a = 8'(ia); b = 8'(ib); fl = 8'(f);
        #1;
        model(o, ia, ib, f, er, ew, ef);
        n_run++;
        if (wr !== 1'(ew)) begin
            n_fail++;
            $display("FAIL R1 op=%0d wr_en actual=%0d expected=%0d", o, wr, ew);
        end
        n_run++;
        if (flo !== 8'(ef)) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h f=%h flags actual=%h expected=%h",
                     req_of(o), o, ia, ib, f, flo, 8'(ef));
        end
        if (ew == 1) begin
            n_run++;
            if (res !== 8'(er)) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                         req_of(o), o, ia, ib, res, 8'(er));
            end
        end
    endtask

    initial begin
        op = 4'd0; a = '0; b = '0; fl = '0;
        repeat (3) @(posedge clk);
        #1;
        n_run++;   // reset state: ADD 0,0 with clear flags
        if (res !== 8'h00 || flo !== 8'h02 || wr !== 1'b1) begin
            n_fail++;
            $display("FAIL R2 reset state actual=%h/%h expected=00/02", res, flo);
        end
        rst = 1'b0;
        // R2: carries and overflow boundaries
        apply(0, 'h7F, 'h01, 'h00);
        apply(0, 'hFF, 'h01, 'h00);
        apply(1, 'h0F, 'h00, 'h01);
        // R3: borrow cases
        apply(2, 'h10, 'h01, 'h00);
        apply(2, 'h00, 'h01, 'h00);
        apply(2, 'h80, 'h01, 'h00);
        // R4: sticky zero chain
        apply(3, 'h05, 'h05, 'h00);
        apply(3, 'h05, 'h05, 'h02);
        apply(5, 'h05, 'h04, 'h03);
        apply(5, 'h05, 'h04, 'h01);
        // R5: compare does not write
        apply(4, 'h33, 'h33, 'h00);
        // R6: decrement edges
        apply(6, 'h80, 'h00, 'h21);
        apply(6, 'h01, 'h00, 'h00);
        apply(6, 'h00, 'h00, 'h00);
        // R7
        apply(7, 'hF0, 'h0F, 'h29);
        apply(8, 'h80, 'h00, 'h00);
        apply(9, 'hAA, 'hAA, 'h08);
        // R8
        apply(10, 'h48, 'h00, 'h00);
        apply(11, 'h80, 'h00, 'h01);
        // R9: T and I set and clear
        apply(12, 'h00, 'h06, 'h00);
        apply(13, 'h00, 'h07, 'hFF);
        // R10
        apply(14, 'h12, 'h34, 'h5A);
        apply(15, 'hFF, 'hFF, 'hA5);
        // random sweep across all codes
        for (int i = 0; i < 4000; i++)
            apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule